// File: doc/BRIEF.md
# Count-Normalizing Shift/Rotate Execution Unit

This unit carries out one shift or rotate on an 8-bit or 16-bit operand, chosen per operation by a width input. It receives a 3-bit operation code, a full 8-bit raw count, the operand, and the incoming carry and overflow flags. In the cycle after a start pulse, it reduces the raw count to an effective count. Plain rotates wrap into 1..16. Carry rotates wrap by the operand width plus one. Shifts saturate at 17. The unit then moves the operand one bit position per clock until the effective count is used up.

When the operation finishes, a one-cycle done pulse marks the result, the new carry and overflow flags, and the zero/sign/parity flags as valid. Zero, sign and parity are valid only for shifts. The unit also reports a cycle-cost figure derived from the raw count and from whether the operand came from memory. Instruction decode and operand fetch or write-back belong to the surrounding pipeline.

Top module: `shrot_unit`

## Requirements
- R1: Operation codes 0 (rotate left), 1 (rotate right), 2 (rotate left through carry) and 3 (rotate right through carry) move the operand one bit per step. The outgoing bit becomes the carry. Codes 2 and 3 feed the previous carry into the vacated bit; codes 0 and 1 feed back the bit that left.
- R2: Codes 4 and 6 both shift left and fill with 0. Code 5 shifts right and fills with 0. Code 7 shifts right and refills the top bit with its own value. In each case the last bit moved out becomes the carry.
- R3: For codes 0 and 1 at either width, a raw count of 0 stays 0, and any other count n gives ((n-1) mod 16)+1.
- R4: For codes 2 and 3, a nonzero count n gives ((n-1) mod 9)+1 at 8-bit width and ((n-1) mod 17)+1 at 16-bit width. A count of 0 stays 0.
- R5: For codes 4 to 7, counts 0 to 16 are used as given, and any count of 17 or more becomes 17.
- R6: An effective count of 0 returns the operand, carry_i and ovf_i unchanged, with arith_upd_o low. Done is high in the cycle after the edge that follows the start-sampling edge.
- R7: With effective count e, done is high for exactly one cycle, in the cycle that follows the (e+1)-th rising edge after the edge that sampled start.
- R8: The overflow flag comes from the last step. For left operations (even codes) it is the result's top bit XOR the new carry. For right operations (odd codes) it is the XOR of the result's two top bits.
- R9: arith_upd_o is high at done exactly for codes 4 to 7 with a nonzero effective count. When it is high, zero_o is 1 if the result at the active width is 0, sign_o is the result's top bit, and parity_o is 1 if the low byte has an even number of ones.
- R10: cost_o at done equals the raw count plus 5 for a register operand (mem_i=0), or plus 8 for a memory operand (mem_i=1).
- R11: At 8-bit width (wide_i=0), the operation uses bits 7..0, and bits 15..8 of the result equal those of the operand.
- R12: A start pulse that arrives while an operation is in progress is ignored, and the running operation completes with its own data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; operands are sampled when idle |
| op_i | input | 3 | Operation code |
| wide_i | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| mem_i | input | 1 | Operand comes from memory (affects cost only) |
| count_i | input | 8 | Raw count |
| operand_i | input | 16 | Operand value |
| carry_i | input | 1 | Incoming carry flag |
| ovf_i | input | 1 | Incoming overflow flag |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Result |
| carry_o | output | 1 | Resulting carry flag |
| ovf_o | output | 1 | Resulting overflow flag |
| arith_upd_o | output | 1 | Zero/sign/parity outputs are valid |
| zero_o | output | 1 | Result is zero at active width |
| sign_o | output | 1 | Top bit of result at active width |
| parity_o | output | 1 | Even parity of result low byte |
| cost_o | output | 9 | Cycle-cost figure |

## Verification
The assertions assume that start is a single-cycle pulse and that every 3-bit code is legal. They also assume that the operand, count and flag inputs matter only in the cycle where an idle unit samples start. Because of this, the properties on the count register bound, the zero-count path and the narrow upper byte can rely only on captured state.

The stimulus respects these assumptions. It changes inputs only at the falling edge and drops start after one cycle. It waits for done before issuing the next operation, except in one deliberate case where a second start lands while a shift is running. Raw counts are drawn across the full 8-bit range, with extra weight near the wrap and saturation points, and are mixed with directed cases at 0, 9, 16, 17, 18 and 255.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_ROL     = 3'd0,
    OP_ROR     = 3'd1,
    OP_RCL     = 3'd2,
    OP_RCR     = 3'd3,
    OP_SHL     = 3'd4,
    OP_SHR     = 3'd5,
    OP_SHL_ALT = 3'd6,
    OP_SAR     = 3'd7
  } shrot_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_RUN  = 2'd2
  } shrot_state_e;

  // even codes move toward the top bit
  function automatic logic op_is_left(shrot_op_e op);
    return ~op[0];
  endfunction

  function automatic logic op_is_shift(shrot_op_e op);
    return op[2];
  endfunction

  function automatic logic op_is_carry_rot(shrot_op_e op);
    return (op == OP_RCL) || (op == OP_RCR);
  endfunction

endpackage

// File: rtl/shrot_count_norm.sv
module shrot_count_norm
  import shrot_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int EFF_W    = 5
) (
  input  shrot_op_e          op_i,
  input  logic               wide_i,
  input  logic [CNT_W-1:0]   raw_i,
  output logic [EFF_W-1:0]   eff_o
);

  localparam int ROT_SPAN  = DATA_W;
  localparam int RCW_SPAN  = DATA_W + 1;
  localparam int RCN_SPAN  = NARROW_W + 1;
  localparam int SHIFT_SAT = DATA_W + 1;

  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] rot_cnt;
  logic [CNT_W-1:0] rcw_cnt;
  logic [CNT_W-1:0] rcn_cnt;
  logic [CNT_W-1:0] sft_cnt;
  logic [CNT_W-1:0] sel_cnt;

  always_comb begin
    dec     = raw_i - CNT_W'(1);
    rot_cnt = (dec % CNT_W'(ROT_SPAN)) + CNT_W'(1);
    rcw_cnt = (dec % CNT_W'(RCW_SPAN)) + CNT_W'(1);
    rcn_cnt = (dec % CNT_W'(RCN_SPAN)) + CNT_W'(1);
    sft_cnt = (raw_i > CNT_W'(SHIFT_SAT)) ? CNT_W'(SHIFT_SAT) : raw_i;

    if (raw_i == '0) begin
      sel_cnt = '0;
    end else if (op_is_shift(op_i)) begin
      sel_cnt = sft_cnt;
    end else if (op_is_carry_rot(op_i)) begin
      sel_cnt = wide_i ? rcw_cnt : rcn_cnt;
    end else begin
      sel_cnt = rot_cnt;
    end
    eff_o = sel_cnt[EFF_W-1:0];
  end

endmodule

// File: rtl/shrot_step.sv
module shrot_step
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  shrot_op_e      op_i,
  input  logic [W-1:0]   val_i,
  input  logic           cin_i,
  output logic [W-1:0]   val_o,
  output logic           cout_o,
  output logic           ovf_o
);

  always_comb begin
    unique case (op_i)
      OP_ROL: begin
        cout_o = val_i[W-1];
        val_o  = {val_i[W-2:0], val_i[W-1]};
      end
      OP_ROR: begin
        cout_o = val_i[0];
        val_o  = {val_i[0], val_i[W-1:1]};
      end
      OP_RCL: begin
        cout_o = val_i[W-1];
        val_o  = {val_i[W-2:0], cin_i};
      end
      OP_RCR: begin
        cout_o = val_i[0];
        val_o  = {cin_i, val_i[W-1:1]};
      end
      OP_SHR: begin
        cout_o = val_i[0];
        val_o  = {1'b0, val_i[W-1:1]};
      end
      OP_SAR: begin
        cout_o = val_i[0];
        val_o  = {val_i[W-1], val_i[W-1:1]};
      end
      default: begin
        cout_o = val_i[W-1];
        val_o  = {val_i[W-2:0], 1'b0};
      end
    endcase

    if (op_is_left(op_i)) begin
      ovf_o = val_o[W-1] ^ cout_o;
    end else begin
      ovf_o = val_o[W-1] ^ val_o[W-2];
    end
  end

endmodule

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
  import shrot_pkg::*;
#(
  parameter int EFF_W   = 5,
  parameter int MAX_EFF = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EFF_W-1:0] eff_i,
  output logic             capture_o,
  output logic             norm_o,
  output logic             step_o,
  output logic             done_o
);

  shrot_state_e     state_q, state_d;
  logic [EFF_W-1:0] cnt_q, cnt_d;
  logic             done_d;
  logic             cnt_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    cnt_en    = 1'b0;
    capture_o = 1'b0;
    norm_o    = 1'b0;
    step_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          capture_o = 1'b1;
          state_d   = ST_NORM;
        end
      end
      ST_NORM: begin
        norm_o = 1'b1;
        if (eff_i == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          cnt_en  = 1'b1;
          cnt_d   = eff_i;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_q - EFF_W'(1);
        if (cnt_q == EFF_W'(1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5: step counter never exceeds the saturation limit
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= EFF_W'(MAX_EFF));

  // R12: a running operation is never re-captured
  assert_no_recapture_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> !capture_o);

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NARROW_W  = 8,
  parameter int CNT_W     = 8,
  parameter int REG_COST  = 5,
  parameter int MEM_COST  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          op_i,
  input  logic                wide_i,
  input  logic                mem_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic [DATA_W-1:0]   operand_i,
  input  logic                carry_i,
  input  logic                ovf_i,
  output logic                done_o,
  output logic [DATA_W-1:0]   result_o,
  output logic                carry_o,
  output logic                ovf_o,
  output logic                arith_upd_o,
  output logic                zero_o,
  output logic                sign_o,
  output logic                parity_o,
  output logic [CNT_W:0]      cost_o
);

  localparam int MAX_EFF = DATA_W + 1;
  localparam int EFF_W   = $clog2(MAX_EFF + 1);
  localparam int COST_W  = CNT_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  // captured operation
  shrot_op_e          op_q, op_d;
  logic               wide_q, wide_d;
  logic [CNT_W-1:0]   raw_q, raw_d;
  logic [DATA_W-1:0]  val_q, val_d;
  logic               cf_q, cf_d;
  logic               of_q, of_d;
  logic               upd_q, upd_d;
  logic [COST_W-1:0]  cost_q, cost_d;
  logic               reg_en;

  logic [EFF_W-1:0]   eff;
  logic               capture, norm, step;

  logic [NARROW_W-1:0] n_val;
  logic                n_c, n_o;
  logic [DATA_W-1:0]   w_val;
  logic                w_c, w_o;

  shrot_count_norm #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .EFF_W(EFF_W)
  ) u_norm (
    .op_i  (op_q),
    .wide_i(wide_q),
    .raw_i (raw_q),
    .eff_o (eff)
  );

  shrot_ctrl #(.EFF_W(EFF_W), .MAX_EFF(MAX_EFF)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .start_i  (start_i),
    .eff_i    (eff),
    .capture_o(capture),
    .norm_o   (norm),
    .step_o   (step),
    .done_o   (done_o)
  );

  shrot_step #(.W(NARROW_W)) u_step_n (
    .op_i  (op_q),
    .val_i (val_q[NARROW_W-1:0]),
    .cin_i (cf_q),
    .val_o (n_val),
    .cout_o(n_c),
    .ovf_o (n_o)
  );

  shrot_step #(.W(DATA_W)) u_step_w (
    .op_i  (op_q),
    .val_i (val_q),
    .cin_i (cf_q),
    .val_o (w_val),
    .cout_o(w_c),
    .ovf_o (w_o)
  );

  always_comb begin
    op_d   = op_q;
    wide_d = wide_q;
    raw_d  = raw_q;
    val_d  = val_q;
    cf_d   = cf_q;
    of_d   = of_q;
    upd_d  = upd_q;
    cost_d = cost_q;
    reg_en = capture | norm | step;
    if (capture) begin
      op_d   = shrot_op_e'(op_i);
      wide_d = wide_i;
      raw_d  = count_i;
      val_d  = operand_i;
      cf_d   = carry_i;
      of_d   = ovf_i;
      upd_d  = 1'b0;
      cost_d = (mem_i ? COST_W'(MEM_COST) : COST_W'(REG_COST)) + COST_W'(count_i);
    end else if (norm) begin
      upd_d = (eff != '0) && op_is_shift(op_q);
    end else if (step) begin
      if (wide_q) begin
        val_d = w_val;
        cf_d  = w_c;
        of_d  = w_o;
      end else begin
        val_d = {val_q[DATA_W-1:NARROW_W], n_val};
        cf_d  = n_c;
        of_d  = n_o;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ROL;
      wide_q <= 1'b0;
      raw_q  <= '0;
      val_q  <= '0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
      upd_q  <= 1'b0;
      cost_q <= '0;
    end else if (reg_en) begin
      op_q   <= op_d;
      wide_q <= wide_d;
      raw_q  <= raw_d;
      val_q  <= val_d;
      cf_q   <= cf_d;
      of_q   <= of_d;
      upd_q  <= upd_d;
      cost_q <= cost_d;
    end
  end

  assign result_o    = val_q;
  assign carry_o     = cf_q;
  assign ovf_o       = of_q;
  assign arith_upd_o = upd_q;
  assign cost_o      = cost_q;
  assign zero_o      = wide_q ? (val_q == '0) : (val_q[NARROW_W-1:0] == '0);
  assign sign_o      = wide_q ? val_q[DATA_W-1] : val_q[NARROW_W-1];
  assign parity_o    = ~^val_q[NARROW_W-1:0];

  // R6: zero effective count completes next cycle with data untouched
  assert_zero_count_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (norm && (eff == '0)) |=> (done_o && (result_o == $past(val_q)) &&
                               (carry_o == $past(cf_q)) && !arith_upd_o));

  // R4: narrow carry rotates never exceed width plus one steps
  assert_rc_narrow_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (norm && op_is_carry_rot(op_q) && !wide_q) |-> (eff <= EFF_W'(NARROW_W + 1)));

  // R11: narrow steps leave the upper byte alone
  assert_narrow_upper_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (step && !wide_q) |=> (val_q[DATA_W-1:NARROW_W] == $past(val_q[DATA_W-1:NARROW_W])));

  // R10: reported cost is at least the register base
  assert_cost_floor_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (cost_o >= COST_W'(REG_COST)));

  // R9: arithmetic flags only flagged for shift codes
  assert_upd_shift_only_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && arith_upd_o) |-> op_is_shift(op_q));

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic        wide, mem;
  logic [7:0]  count;
  logic [15:0] operand;
  logic        cin, oin;
  logic        done;
  logic [15:0] result;
  logic        cout, oout, upd, zf, sf, pf;
  logic [8:0]  cost;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  shrot_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wide_i(wide),
    .mem_i(mem), .count_i(count), .operand_i(operand), .carry_i(cin),
    .ovf_i(oin), .done_o(done), .result_o(result), .carry_o(cout),
    .ovf_o(oout), .arith_upd_o(upd), .zero_o(zf), .sign_o(sf),
    .parity_o(pf), .cost_o(cost)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_of(input int o, input bit w, input int raw);
    if (raw == 0) return 0;
    if (o >= 4) return (raw > 17) ? 17 : raw;
    if (o == 2 || o == 3) return ((raw - 1) % (w ? 17 : 9)) + 1;
    return ((raw - 1) % 16) + 1;
  endfunction

  task automatic run_op(input int o, input bit w, input bit m, input int raw,
                        input int opnd, input bit ci, input bit oi,
                        input string req, input bit busy_poke);
    int W    = w ? 16 : 8;
    int mask = w ? 32'hFFFF : 32'hFF;
    int v    = w ? opnd : (opnd & 32'hFF);
    int c    = ci;
    int ov   = oi;
    int e    = eff_of(o, w, raw);
    int top, k, exp_res, exp_zf, exp_sf, exp_pf, ones;
    bit got;
    for (int i = 0; i < e; i++) begin
      top = (v >> (W - 1)) & 1;
      case (o)
        0: begin c = top;   v = ((v << 1) | top) & mask; end
        1: begin top = v & 1; c = top; v = (v >> 1) | (top << (W - 1)); end
        2: begin v = ((v << 1) | c) & mask; c = top; end
        3: begin top = v & 1; v = (v >> 1) | (c << (W - 1)); c = top; end
        5: begin c = v & 1; v = v >> 1; end
        7: begin c = v & 1; v = (v >> 1) | (top << (W - 1)); end
        default: begin c = top; v = (v << 1) & mask; end
      endcase
      if ((o & 1) == 0) ov = ((v >> (W - 1)) & 1) ^ c;
      else ov = ((v >> (W - 1)) & 1) ^ ((v >> (W - 2)) & 1);
    end
    exp_res = w ? v : ((opnd & 32'hFF00) | v);
    exp_zf  = (v == 0);
    exp_sf  = (v >> (W - 1)) & 1;
    ones = 0;
    for (int b = 0; b < 8; b++) ones += (v >> b) & 1;
    exp_pf = ((ones % 2) == 0);

    op = o[2:0]; wide = w; mem = m; count = raw[7:0];
    operand = opnd[15:0]; cin = ci; oin = oi; start = 1'b1;
    k = 0; got = 0;
    while (!got && k < 40) begin
      @(negedge clk);
      k++;
      if (k == 1) start = 1'b0;
      if (busy_poke && k == 2) begin
        start = 1'b1; operand = 16'h1234; count = 8'd0; op = 3'd1;
      end
      if (busy_poke && k == 3) start = 1'b0;
      if (done) got = 1;
    end
    check(got, "R7", "done seen", got, 1);
    check(k == e + 2, (e == 0) ? "R6" : "R7", "done latency", k, e + 2);
    check(result == exp_res[15:0], req, "result", result, exp_res);
    check(cout == c[0], req, "carry", cout, c);
    check(oout == ov[0], "R8", "overflow", oout, ov);
    check(upd == ((o >= 4) && (e != 0)), "R9", "arith_upd", upd, (o >= 4) && (e != 0));
    if ((o >= 4) && (e != 0)) begin
      check(zf == exp_zf[0] && sf == exp_sf[0] && pf == exp_pf[0], "R9",
            "zero/sign/parity", {zf, sf, pf}, {exp_zf[0], exp_sf[0], exp_pf[0]});
    end
    check(cost == 9'((m ? 8 : 5) + raw), "R10", "cost", cost, (m ? 8 : 5) + raw);
    @(negedge clk);
    check(!done, "R7", "done single pulse", done, 0);
    if (busy_poke) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        check(!done && result == exp_res[15:0], "R12", "ignored start", result, exp_res);
      end
    end
  endtask

  initial begin
    #(5ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int o, raw;
    process::self().srandom(32'd1357);
    rst_n = 1'b0; start = 1'b0; op = '0; wide = 1'b0; mem = 1'b0;
    count = '0; operand = '0; cin = 1'b0; oin = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && result == 16'h0 && !cout && !oout && !upd && cost == 0,
          "R6", "reset state", result, 0);

    // directed corners
    run_op(0, 1, 0, 0,   16'hA5C3, 1, 1, "R6", 0);
    run_op(0, 1, 0, 16,  16'h8001, 0, 0, "R3", 0);
    run_op(1, 0, 1, 17,  16'h3381, 0, 0, "R3", 0);
    run_op(0, 0, 0, 255, 16'h0096, 1, 0, "R3", 0);
    run_op(2, 0, 0, 9,   16'h00C1, 1, 0, "R4", 0);
    run_op(3, 0, 0, 10,  16'h5503, 0, 1, "R4", 0);
    run_op(2, 1, 1, 17,  16'h8421, 1, 0, "R4", 0);
    run_op(3, 1, 0, 18,  16'h0001, 0, 0, "R4", 0);
    run_op(4, 1, 0, 17,  16'hFFFF, 0, 1, "R5", 0);
    run_op(6, 0, 0, 1,   16'h7740, 0, 0, "R2", 0);
    run_op(5, 1, 0, 16,  16'h8000, 0, 0, "R5", 0);
    run_op(7, 1, 1, 200, 16'h9000, 0, 0, "R5", 0);
    run_op(7, 0, 0, 3,   16'hEE90, 0, 0, "R11", 0);
    run_op(1, 1, 0, 1,   16'h0001, 0, 0, "R1", 0);
    run_op(4, 1, 0, 5,   16'h0F0F, 0, 0, "R12", 1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      o = $urandom_range(0, 7);
      if ($urandom_range(0, 3) == 0) raw = $urandom_range(0, 255);
      else raw = $urandom_range(0, 36);
      run_op(o, $urandom_range(0, 1), $urandom_range(0, 1), raw,
             $urandom_range(0, 65535), $urandom_range(0, 1), $urandom_range(0, 1),
             (o >= 4) ? "R2" : "R1", 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule